// File: doc/BRIEF.md
# Self-Recovering Control State Machine

A five-state control sequencer that guards its own state register against corruption. A primary state register holds the state in either a 3-bit binary code or a 5-bit one-hot code, selected by a parameter. Every bit pattern that is not one of the five legal codes is decoded by name. On the next clock edge the machine returns to the first state and emits a single-cycle recovery-reset request.

A shadow register runs beside the primary. It computes its own next state from its own present value and the same two condition inputs. The two registers are compared on every cycle. A disagreement catches a jump between two legal states that the transition rules do not permit, which no illegal-code decoding can detect. On a disagreement, both registers return to the first state and a sticky mismatch flag is raised. A fault-injection port lets a testbench overwrite the primary register with any pattern.

The output is a 2-bit group indication. The first state has its own group. The second and third states share a group, the fourth and fifth states share another, and a fourth group value marks an illegal code.

Top module: `safe_fsm`

## Requirements
- R1: Asserting rst_ni low sets both registers to the first state S1 at once, without a clock edge, and clears rst_req_o and mismatch_o.
- R2: From S1 the machine moves to S2 when cond_a_i is 1 and otherwise stays in S1.
- R3: S2 always moves to S3. S3 moves to S4 when cond_b_i is 1 and otherwise stays in S3.
- R4: S4 always moves to S5, and S5 always moves to S1.
- R5: group_o is 2'b00 for S1, 2'b01 for S2 or S3, 2'b10 for S4 or S5, and 2'b11 while the primary register holds an illegal code. It reflects the primary register combinationally.
- R6: With ONE_HOT=0, states S1..S5 are codes 0..4, and codes 5, 6 and 7 are illegal. With ONE_HOT=1, state Sk is the pattern with only bit k-1 set, and all other 27 patterns are illegal.
- R7: When inj_en_i is 1 at a clock edge, the primary register loads inj_code_i and the shadow register advances normally. Recovery at the same edge takes priority over injection.
- R8: If the primary register holds an illegal code at a clock edge, both registers load S1 and rst_req_o is 1 for the following cycle.
- R9: If the primary and shadow registers differ at a clock edge, both registers load S1 and mismatch_o becomes 1. mismatch_o then stays 1 until reset.
- R10: A disagreement in which the primary register holds a legal code sets mismatch_o but leaves rst_req_o at 0.
- R11: rst_req_o is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cond_a_i | input | 1 | Condition steering S1 to S2 |
| cond_b_i | input | 1 | Condition steering S3 to S4 |
| inj_en_i | input | 1 | Overwrite the primary register at this edge |
| inj_code_i | input | W (3 or 5) | Pattern loaded by injection |
| group_o | output | 2 | State group of the primary register |
| rst_req_o | output | 1 | One-cycle recovery reset request |
| mismatch_o | output | 1 | Sticky primary/shadow disagreement flag |

## Verification
The illegal-code recovery and the shadow comparison fall in the same cycle whenever an illegal pattern is injected, because a legal shadow value can never equal an illegal primary value. The bench provokes this for every pattern of both encodings, from each of the five legal states. Each case must produce the reset request and the mismatch flag on the same edge, with the group returning to S1. Injected patterns that are legal but disagree with the shadow are judged separately: they must raise only the mismatch flag. Injected patterns that equal the shadow must raise neither flag.

// File: rtl/safe_fsm_pkg.sv
package safe_fsm_pkg;
  localparam int NUM_ST = 5;
  localparam int ST_W   = 3;

  typedef enum logic [ST_W-1:0] {
    ST_1 = 3'd0, ST_2 = 3'd1, ST_3 = 3'd2, ST_4 = 3'd3, ST_5 = 3'd4
  } fsm_st_e;

  typedef enum logic [1:0] {
    GRP_IDLE = 2'b00, GRP_MID = 2'b01, GRP_END = 2'b10, GRP_BAD = 2'b11
  } fsm_grp_e;

  function automatic int code_width(bit one_hot);
    return one_hot ? NUM_ST : ST_W;
  endfunction

  function automatic fsm_st_e next_st(fsm_st_e st, logic a, logic b);
    case (st)
      ST_1:    return a ? ST_2 : ST_1;
      ST_2:    return ST_3;
      ST_3:    return b ? ST_4 : ST_3;
      ST_4:    return ST_5;
      ST_5:    return ST_1;
      default: return ST_1;
    endcase
  endfunction

  function automatic fsm_grp_e st_group(fsm_st_e st);
    case (st)
      ST_1:       return GRP_IDLE;
      ST_2, ST_3: return GRP_MID;
      ST_4, ST_5: return GRP_END;
      default:    return GRP_BAD;
    endcase
  endfunction
endpackage

// File: rtl/safe_fsm_codec.sv
module safe_fsm_codec
  import safe_fsm_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0,
  parameter int W       = code_width(ONE_HOT)
) (
  input  logic [W-1:0] code_i,
  input  fsm_st_e      st_i,
  output logic         valid_o,
  output fsm_st_e      st_o,
  output logic [W-1:0] code_o
);
  if (ONE_HOT) begin : g_onehot
    always_comb begin
      valid_o = 1'b0;
      st_o    = ST_1;
      for (int i = 0; i < NUM_ST; i++) begin
        if (code_i == (W'(1) << i)) begin
          valid_o = 1'b1;
          st_o    = fsm_st_e'(ST_W'(i));
        end
      end
    end
    assign code_o = W'(1) << st_i;
  end else begin : g_binary
    assign valid_o = (code_i < W'(NUM_ST));
    assign st_o    = valid_o ? fsm_st_e'(code_i[ST_W-1:0]) : ST_1;
    assign code_o  = W'(st_i);
  end
endmodule

// File: rtl/safe_fsm_step.sv
module safe_fsm_step
  import safe_fsm_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0,
  parameter int W       = code_width(ONE_HOT)
) (
  input  logic [W-1:0] code_i,
  input  logic         cond_a_i,
  input  logic         cond_b_i,
  output logic [W-1:0] nxt_o,
  output logic         illegal_o,
  output logic [1:0]   grp_o
);
  logic    valid;
  fsm_st_e cur_st, nxt_st;

  safe_fsm_codec #(.ONE_HOT(ONE_HOT), .W(W)) i_codec (
    .code_i (code_i),
    .st_i   (nxt_st),
    .valid_o(valid),
    .st_o   (cur_st),
    .code_o (nxt_o)
  );

  // unused codes are decoded by name and steered to S1
  assign nxt_st    = valid ? next_st(cur_st, cond_a_i, cond_b_i) : ST_1;
  assign illegal_o = !valid;
  assign grp_o     = valid ? st_group(cur_st) : GRP_BAD;
endmodule

// File: rtl/safe_fsm.sv
module safe_fsm
  import safe_fsm_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0,
  localparam int W      = code_width(ONE_HOT)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cond_a_i,
  input  logic         cond_b_i,
  input  logic         inj_en_i,
  input  logic [W-1:0] inj_code_i,
  output logic [1:0]   group_o,
  output logic         rst_req_o,
  output logic         mismatch_o
);
  localparam logic [W-1:0] S1_CODE = ONE_HOT ? W'(1) : W'(0);

  logic [W-1:0] pri_q, sh_q, pri_nxt, sh_nxt;
  logic         pri_ill, sh_ill, rst_req_q, mism_q, differ;
  logic [1:0]   pri_grp, sh_grp;

  safe_fsm_step #(.ONE_HOT(ONE_HOT), .W(W)) i_pri (
    .code_i(pri_q), .cond_a_i(cond_a_i), .cond_b_i(cond_b_i),
    .nxt_o(pri_nxt), .illegal_o(pri_ill), .grp_o(pri_grp)
  );

  safe_fsm_step #(.ONE_HOT(ONE_HOT), .W(W)) i_sh (
    .code_i(sh_q), .cond_a_i(cond_a_i), .cond_b_i(cond_b_i),
    .nxt_o(sh_nxt), .illegal_o(sh_ill), .grp_o(sh_grp)
  );

  assign differ = (pri_q != sh_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_q     <= S1_CODE;
      sh_q      <= S1_CODE;
      rst_req_q <= 1'b0;
      mism_q    <= 1'b0;
    end else begin
      // recovery outranks injection
      if (pri_ill || differ) begin
        pri_q <= S1_CODE;
        sh_q  <= S1_CODE;
      end else begin
        pri_q <= inj_en_i ? inj_code_i : pri_nxt;
        sh_q  <= sh_nxt;
      end
      rst_req_q <= pri_ill;
      mism_q    <= mism_q | differ;
    end
  end

  assign group_o    = pri_grp;
  assign rst_req_o  = rst_req_q;
  assign mismatch_o = mism_q;

  // R8
  illegal_recover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pri_ill |=> (group_o == GRP_IDLE && rst_req_o));
  // R11
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  // R9
  mismatch_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch_o |=> mismatch_o);
  // R9
  shadow_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    differ |=> (mismatch_o && group_o == GRP_IDLE));
  // R10
  legal_mism_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pri_ill && differ) |=> !rst_req_o);
  // R5
  no_bad_grp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inj_en_i |=> group_o != GRP_BAD);
  // R7
  shadow_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sh_ill && sh_grp != GRP_BAD));
endmodule

// File: tb/test_safe_fsm.sv
module test_safe_fsm;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cond_a = 1'b0, cond_b = 1'b0;
  logic inj_b = 1'b0, inj_o = 1'b0;
  logic [2:0] code_b = '0;
  logic [4:0] code_o = '0;
  logic [1:0] grp_b, grp_o;
  logic req_b, req_o, mis_b, mis_o;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  safe_fsm #(.ONE_HOT(1'b0)) i_safe_fsm (
    .clk_i(clk), .rst_ni(rst_ni), .cond_a_i(cond_a), .cond_b_i(cond_b),
    .inj_en_i(inj_b), .inj_code_i(code_b),
    .group_o(grp_b), .rst_req_o(req_b), .mismatch_o(mis_b)
  );

  safe_fsm #(.ONE_HOT(1'b1)) i_safe_fsm_oh (
    .clk_i(clk), .rst_ni(rst_ni), .cond_a_i(cond_a), .cond_b_i(cond_b),
    .inj_en_i(inj_o), .inj_code_i(code_o),
    .group_o(grp_o), .rst_req_o(req_o), .mismatch_o(mis_o)
  );

  // walk table: {cond_a, cond_b, expected group, requirement tag}
  localparam logic [7:0] WALK [12] = '{
    {1'b0, 1'b0, 2'b00, 4'd2}, {1'b0, 1'b1, 2'b00, 4'd2},
    {1'b1, 1'b0, 2'b01, 4'd2}, {1'b0, 1'b0, 2'b01, 4'd3},
    {1'b1, 1'b0, 2'b01, 4'd3}, {1'b0, 1'b1, 2'b10, 4'd3},
    {1'b0, 1'b0, 2'b10, 4'd4}, {1'b1, 1'b1, 2'b00, 4'd4},
    {1'b1, 1'b1, 2'b01, 4'd2}, {1'b1, 1'b1, 2'b01, 4'd3},
    {1'b1, 1'b1, 2'b10, 4'd3}, {1'b1, 1'b1, 2'b10, 4'd4}
  };

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int m_next(int k, bit a, bit b);
    case (k)
      0: return a ? 1 : 0;
      1: return 2;
      2: return b ? 3 : 2;
      3: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int m_grp(int k);
    return (k == 0) ? 0 : (k <= 2) ? 1 : 2;
  endfunction

  // R6 encodings
  function automatic int m_enc(int k, bit oh);
    return oh ? (1 << k) : k;
  endfunction

  function automatic int m_dec(int c, bit oh);
    for (int k = 0; k < 5; k++) if (m_enc(k, oh) == c) return k;
    return -1;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    cond_a = 1'b0; cond_b = 1'b0; inj_b = 1'b0; inj_o = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic goto_state(int k);
    for (int j = 0; j < k; j++) begin
      cond_a = (j == 0); cond_b = (j == 2);
      @(posedge clk); @(negedge clk);
    end
    cond_a = 1'b0; cond_b = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got 0 expected 1 (run ended)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 group", grp_b, 0); chk("R1 group oh", grp_o, 0);
    chk("R1 req", req_b, 0);   chk("R1 mism", mis_b, 0);

    // R2 R3 R4 R5 transition walk
    for (int i = 0; i < 12; i++) begin
      cond_a = WALK[i][7]; cond_b = WALK[i][6];
      @(posedge clk); @(negedge clk);
      chk($sformatf("R%0d step %0d", WALK[i][3:0], i), grp_b, int'(WALK[i][5:4]));
      chk($sformatf("R%0d oh step %0d", WALK[i][3:0], i), grp_o, int'(WALK[i][5:4]));
    end
    cond_a = 1'b0; cond_b = 1'b0;

    // R1 asynchronous reset mid-cycle clears a sticky flag
    do_reset(); goto_state(1);
    inj_b = 1'b1; code_b = 3'd3;
    @(posedge clk); @(negedge clk); inj_b = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R9 set before reset", mis_b, 1);
    #2 rst_ni = 1'b0; #1;
    chk("R1 async mism", mis_b, 0); chk("R1 async group", grp_b, 0);
    @(negedge clk); rst_ni = 1'b1;

    // R6 R7 R8 R9 R10 R11: every pattern injected from every legal state
    for (int oh = 0; oh < 2; oh++) begin
      for (int k = 0; k < 5; k++) begin
        for (int c = 0; c < (oh ? 32 : 8); c++) begin
          int sh, dk, gexp;
          bit legal, fault;
          do_reset(); goto_state(k);
          sh = m_next(k, 1'b0, 1'b0);
          dk = m_dec(c, oh[0]);
          legal = (dk >= 0);
          fault = !legal || (c != m_enc(sh, oh[0]));
          if (oh) begin inj_o = 1'b1; code_o = 5'(c); end
          else    begin inj_b = 1'b1; code_b = 3'(c); end
          @(posedge clk); @(negedge clk);
          inj_b = 1'b0; inj_o = 1'b0;
          gexp = legal ? m_grp(dk) : 3;
          chk($sformatf("R7 R5 oh=%0d k=%0d c=%0d group", oh, k, c), oh ? grp_o : grp_b, gexp);
          chk($sformatf("R7 oh=%0d k=%0d c=%0d no early req", oh, k, c), oh ? req_o : req_b, 0);
          @(posedge clk); @(negedge clk);
          chk($sformatf("R8 R10 oh=%0d k=%0d c=%0d req", oh, k, c), oh ? req_o : req_b, !legal);
          chk($sformatf("R9 oh=%0d k=%0d c=%0d mism", oh, k, c), oh ? mis_o : mis_b, fault);
          gexp = fault ? 0 : m_grp(m_next(sh, 1'b0, 1'b0));
          chk($sformatf("R8 R9 oh=%0d k=%0d c=%0d recover", oh, k, c), oh ? grp_o : grp_b, gexp);
          @(posedge clk); @(negedge clk);
          chk($sformatf("R11 oh=%0d k=%0d c=%0d pulse", oh, k, c), oh ? req_o : req_b, 0);
          chk($sformatf("R9 oh=%0d k=%0d c=%0d sticky", oh, k, c), oh ? mis_o : mis_b, fault);
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule